// File: doc/BRIEF.md
# Serial Register-Access Slave

This block is a two-wire serial bus slave that lets a bus master read and write an 8-bit register file indexed by an 8-bit pointer. The clock line is an input only. The data line is open-drain: the block outputs a pull-low enable and samples the resolved line level. Toward the core it presents an index, a write-data byte, a one-cycle write strobe and a read-data input. The core supplies the read-data byte combinationally from the index.

The block answers to the 7-bit address 0x2F, so the write-direction address byte is 0x5E. A master uses one of three transactions:
- a full write: address, index, data;
- an index-only write: address, index, then a stop, which only moves the pointer;
- a read: address with the direction bit set, after which the slave returns the byte at the pointer.

A read carries no index of its own. The pointer therefore keeps its value across transactions, and a read never changes it. Both lines pass through a two-flop synchroniser and a run-length glitch filter before the block looks for start and stop conditions and clock edges.

Top module: `smbus_reg_slave`

## Requirements
- R1: Out of reset the block drives nothing on the data line (`sdaOe`=0), issues no write strobe, and holds the pointer `regIdx` at 0.
- R2: An address byte whose upper 7 bits equal 0x2F is acknowledged by pulling the data line low during the ninth clock. An address byte with any other value is not acknowledged.
- R3: In a full write (address with bit 0 = 0, index byte, data byte), the slave acknowledges all three bytes. After the eighth bit of the data byte it pulses `regWrEn` for exactly one cycle, with `regIdx` equal to the index byte and `regWrData` equal to the data byte.
- R4: An index-only transaction (address, index byte, stop) loads the pointer `regIdx` with the index byte and writes no register.
- R5: A read (address with bit 0 = 1) returns the byte at the pointer, most significant bit first, one bit per clock. The pointer is unchanged by the read, so repeated reads return the same byte.
- R6: After an address that does not match, the slave ignores the bus until the next start. It acknowledges no byte, writes nothing and leaves the pointer as it was.
- R7: A stop or start seen before the eighth bit of a byte has been received abandons the transaction without writing any register.
- R8: Bytes that follow the first data byte of a write are not acknowledged and not written.
- R9: The slave changes its data-line drive only while the clock line is low. It stops driving at the falling clock edge that ends each acknowledge or data bit it sent.
- R10: A pulse on the data line shorter than the filter length (3 clock cycles) while the clock line is high is not taken as a start or stop.
- R11: A repeated start, with no stop in between, begins a new address phase. A read after an index-only phase closed by a repeated start returns the byte at the new index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Resolved serial data line level |
| sdaOe | output | 1 | 1 pulls the data line low |
| regIdx | output | 8 | Register pointer toward the core |
| regWrData | output | 8 | Byte to write at `regIdx` |
| regWrEn | output | 1 | One-cycle write strobe |
| regRdData | input | 8 | Core's byte at `regIdx` |

## Verification
The clocked properties assume the serial clock stays in each level longer than the synchroniser-plus-filter delay of about seven system cycles. They also assume the data line changes only while the clock is low, except at start and stop. The bench keeps to both assumptions by running every serial half-bit for 12 system cycles. It moves its own data line only after a falling clock edge, apart from deliberate start, stop and sub-filter glitch events. The bench models the open-drain line as the AND of the master's level and the inverse of `sdaOe`.

// File: rtl/smbs_pkg.sv
package smbs_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic shiftIn;   // sample one received bit
    logic loadIdx;   // received byte becomes the pointer
    logic wrReg;     // received byte is written at the pointer
    logic loadTx;    // fetch core byte into the transmit shifter
    logic shiftTx;   // advance the transmit shifter
  } strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_IDX,
    ST_DATA,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_IGNORE
  } state_t;

endpackage

// File: rtl/smbs_sync.sv
module smbs_sync #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclRaw,
  input  logic sdaRaw,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet,
  output logic sdaVal
);
  localparam int LINES  = 2;
  localparam int FCNT_W = $clog2(FILT_LEN + 1);

  logic [LINES-1:0] rawVec;
  logic [LINES-1:0] filtVec;
  logic [LINES-1:0] prevVec;

  assign rawVec = {sdaRaw, sclRaw};

  // One synchroniser and run-length filter per line
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [SYNC_STAGES-1:0] syncQ;
    logic [FCNT_W-1:0]      runCnt;
    logic                   filtQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ  <= '1;
        runCnt <= '0;
        filtQ  <= 1'b1;
      end else begin
        syncQ <= {syncQ[SYNC_STAGES-2:0], rawVec[g]};
        if (syncQ[SYNC_STAGES-1] != filtQ) begin
          if (runCnt == FCNT_W'(FILT_LEN - 1)) begin
            filtQ  <= syncQ[SYNC_STAGES-1];
            runCnt <= '0;
          end else begin
            runCnt <= runCnt + 1'b1;
          end
        end else begin
          runCnt <= '0;
        end
      end
    end

    assign filtVec[g] = filtQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevVec <= '1;
    else       prevVec <= filtVec;
  end

  assign sclRise  =  filtVec[0] & ~prevVec[0];
  assign sclFall  = ~filtVec[0] &  prevVec[0];
  assign startDet =  prevVec[1] & ~filtVec[1] & filtVec[0] & prevVec[0];
  assign stopDet  = ~prevVec[1] &  filtVec[1] & filtVec[0] & prevVec[0];
  assign sdaVal   =  filtVec[1];

endmodule

// File: rtl/smbs_ctrl.sv
module smbs_ctrl
  import smbs_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SLV_ADDR = 7'h2F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              txMsb,
  output strobe_t           stb,
  output logic              sdaOe
);
  localparam int ADDR_W = DATA_W - 1;
  localparam int CNT_W  = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(DATA_W + 1);

  state_t           state, stNext;
  state_t           retState, retNext;
  logic [CNT_W-1:0] bitCnt, cntNext;
  logic             oeNext;

  always_comb begin
    stNext  = state;
    retNext = retState;
    cntNext = bitCnt;
    oeNext  = sdaOe;
    stb     = '0;
    if (startDet) begin
      stNext  = ST_ADDR;
      cntNext = '0;
      oeNext  = 1'b0;
    end else if (stopDet) begin
      stNext  = ST_IDLE;
      cntNext = '0;
      oeNext  = 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_IDX, ST_DATA: begin
          if (sclRise && bitCnt < LAST_BIT) begin
            stb.shiftIn = 1'b1;
            cntNext     = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == LAST_BIT) begin
            if (state == ST_ADDR) begin
              if (rxByte[DATA_W-1:1] == ADDR_W'(SLV_ADDR)) begin
                oeNext     = 1'b1;
                stNext     = ST_ACK;
                retNext    = rxByte[0] ? ST_TX : ST_IDX;
                stb.loadTx = rxByte[0];
              end else begin
                stNext = ST_IGNORE;
              end
            end else if (state == ST_IDX) begin
              stb.loadIdx = 1'b1;
              oeNext      = 1'b1;
              stNext      = ST_ACK;
              retNext     = ST_DATA;
            end else begin
              stb.wrReg = 1'b1;
              oeNext    = 1'b1;
              stNext    = ST_ACK;
              retNext   = ST_IGNORE;
            end
          end
        end
        ST_ACK: begin
          if (sclRise) begin
            cntNext = ACK_BIT;
          end else if (sclFall && bitCnt == ACK_BIT) begin
            cntNext = '0;
            stNext  = retState;
            oeNext  = (retState == ST_TX) ? ~txMsb : 1'b0;
          end
        end
        ST_TX: begin
          if (sclRise && bitCnt < LAST_BIT) begin
            stb.shiftTx = 1'b1;
            cntNext     = bitCnt + 1'b1;
          end else if (sclFall) begin
            if (bitCnt == LAST_BIT) begin
              oeNext  = 1'b0;
              cntNext = '0;
              stNext  = ST_MACK;
            end else begin
              oeNext = ~txMsb;
            end
          end
        end
        ST_MACK: begin
          if (sclRise) stNext = ST_IGNORE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      retState <= ST_IDLE;
      bitCnt   <= '0;
      sdaOe    <= 1'b0;
    end else begin
      state    <= stNext;
      retState <= retNext;
      bitCnt   <= cntNext;
      sdaOe    <= oeNext;
    end
  end

endmodule

// File: rtl/smbs_dpath.sv
module smbs_dpath
  import smbs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              sdaVal,
  input  logic [DATA_W-1:0] regRdData,
  output logic [DATA_W-1:0] rxByte,
  output logic              txMsb,
  output logic [DATA_W-1:0] regIdx,
  output logic [DATA_W-1:0] regWrData,
  output logic              regWrEn
);
  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] idxPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
      idxPtr  <= '0;
    end else begin
      if (stb.shiftIn) rxShift <= {rxShift[DATA_W-2:0], sdaVal};
      if (stb.loadIdx) idxPtr  <= rxShift;
      if (stb.loadTx)       txShift <= regRdData;
      else if (stb.shiftTx) txShift <= {txShift[DATA_W-2:0], 1'b0};
    end
  end

  assign rxByte    = rxShift;
  assign txMsb     = txShift[DATA_W-1];
  assign regIdx    = idxPtr;
  assign regWrData = rxShift;
  assign regWrEn   = stb.wrReg;

endmodule

// File: rtl/smbus_reg_slave.sv
module smbus_reg_slave
  import smbs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SLV_ADDR    = 7'h2F,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  output logic [DATA_W-1:0] regIdx,
  output logic [DATA_W-1:0] regWrData,
  output logic              regWrEn,
  input  logic [DATA_W-1:0] regRdData
);
  logic              sclRise, sclFall, startDet, stopDet, sdaVal;
  logic [DATA_W-1:0] rxByte;
  logic              txMsb;
  strobe_t           stb;

  smbs_sync #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sync (
    .clk(clk), .rstN(rstN), .sclRaw(sclIn), .sdaRaw(sdaIn),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet),
    .stopDet(stopDet), .sdaVal(sdaVal)
  );

  smbs_ctrl #(.DATA_W(DATA_W), .SLV_ADDR(SLV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .rxByte(rxByte),
    .txMsb(txMsb), .stb(stb), .sdaOe(sdaOe)
  );

  smbs_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaVal(sdaVal),
    .regRdData(regRdData), .rxByte(rxByte), .txMsb(txMsb),
    .regIdx(regIdx), .regWrData(regWrData), .regWrEn(regWrEn)
  );

endmodule

// File: rtl/smbus_reg_slave_chk.sv
module smbus_reg_slave_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaOe,
  input logic [DATA_W-1:0] regIdx,
  input logic              regWrEn
);
  // R9
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> !sclIn);

  // R3
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  // R3
  wr_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> sdaOe);

  // R9
  wr_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> !sdaOe);

  // R5
  wr_idx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> $stable(regIdx));

endmodule

bind smbus_reg_slave smbus_reg_slave_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe),
  .regIdx(regIdx), .regWrEn(regWrEn)
);

// File: tb/smbus_reg_slave_tb_top.sv
module smbus_reg_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 12;
  localparam int WD_LIMIT   = 190000;
  localparam logic [6:0] MY_ADDR = 7'h2F;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       mScl = 1'b1;
  logic       mSda = 1'b1;
  logic       sdaOe;
  logic       sdaLine;
  logic [7:0] regIdx, regWrData, regRdData;
  logic       regWrEn;
  logic [7:0] regMem [256];
  logic [7:0] expMem [256];
  int         checks = 0;
  int         errors = 0;
  int         wrCount = 0;
  int         cycles = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign sdaLine   = mSda & ~sdaOe;
  assign regRdData = regMem[regIdx];

  smbus_reg_slave dut_i (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine),
    .sdaOe(sdaOe), .regIdx(regIdx), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdData(regRdData)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) regMem[i] <= 8'(i) ^ 8'hA5;
    end else if (regWrEn) begin
      regMem[regIdx] <= regWrData;
      wrCount <= wrCount + 1;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WD_LIMIT) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic busStart();
    mSda = 1'b1; waitClk(HALF);
    mScl = 1'b1; waitClk(HALF);
    mSda = 1'b0; waitClk(HALF);
    mScl = 1'b0; waitClk(2);
  endtask

  task automatic busStop();
    mSda = 1'b0; waitClk(HALF);
    mScl = 1'b1; waitClk(HALF);
    mSda = 1'b1; waitClk(HALF);
  endtask

  task automatic putBit(input bit b, input bit glitch);
    mSda = b; waitClk(HALF);
    mScl = 1'b1;
    if (glitch && b) begin
      waitClk(HALF / 2);
      mSda = 1'b0; waitClk(2);
      mSda = 1'b1; waitClk(HALF - HALF / 2 - 2);
    end else begin
      waitClk(HALF);
    end
    mScl = 1'b0; waitClk(2);
  endtask

  task automatic sendByte(input logic [7:0] b, input bit chkRelease,
                          input int glitchPos, output bit ack);
    for (int i = 7; i >= 0; i--) putBit(b[i], glitchPos == i);
    mSda = 1'b1; waitClk(HALF);
    mScl = 1'b1; waitClk(HALF / 2);
    ack = !sdaLine;
    waitClk(HALF - HALF / 2);
    mScl = 1'b0; waitClk(HALF);
    if (chkRelease)
      chk(sdaOe == 1'b0, "R9 release after ack", int'(sdaOe), 0);
  endtask

  task automatic recvByte(input bit mAck, output logic [7:0] b);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitClk(HALF);
      mScl = 1'b1; waitClk(HALF / 2);
      b[i] = sdaLine;
      waitClk(HALF - HALF / 2);
      mScl = 1'b0; waitClk(2);
    end
    waitClk(HALF);
    chk(sdaOe == 1'b0, "R9 release after data", int'(sdaOe), 0);
    mSda = !mAck; waitClk(2);
    mScl = 1'b1; waitClk(HALF);
    mScl = 1'b0; waitClk(2);
    mSda = 1'b1;
  endtask

  task automatic setIdx(input logic [7:0] idx, input bit withStop);
    bit a0, a1;
    busStart();
    sendByte({MY_ADDR, 1'b0}, 1'b1, -1, a0);
    sendByte(idx, 1'b1, -1, a1);
    chk(a0 && a1, "R4 index-only acks", int'({a0, a1}), 3);
    if (withStop) busStop();
  endtask

  task automatic doRead(output logic [7:0] d);
    bit a0;
    busStart();
    sendByte({MY_ADDR, 1'b1}, 1'b0, -1, a0);
    chk(a0, "R5 read address ack", int'(a0), 1);
    recvByte(1'b0, d);
    busStop();
  endtask

  initial begin
    bit a0, a1, a2, a3;
    logic [7:0] rd, rd2;
    int wrBase;
    for (int i = 0; i < 256; i++) expMem[i] = 8'(i) ^ 8'hA5;
    waitClk(5);
    // R1 reset state
    chk(sdaOe == 1'b0,  "R1 sdaOe reset",   int'(sdaOe), 0);
    chk(regWrEn == 1'b0, "R1 regWrEn reset", int'(regWrEn), 0);
    chk(regIdx == 8'h00, "R1 regIdx reset",  int'(regIdx), 0);
    rstN = 1'b1;
    waitClk(5);
    chk(regIdx == 8'h00, "R1 regIdx after reset", int'(regIdx), 0);

    // R2 / R6 address sweep: only 0x2F acknowledged, nothing written
    wrBase = wrCount;
    for (int a = 0; a < 128; a++) begin
      busStart();
      sendByte({7'(a), 1'b0}, 1'b0, -1, a0);
      busStop();
      chk(a0 == (a == int'(MY_ADDR)), "R2 address match", int'(a0),
          int'(a == int'(MY_ADDR)));
    end
    chk(wrCount == wrBase, "R6 no write in sweep", wrCount, wrBase);

    // R3 / R4 / R5 write sweep with readback
    for (int i = 0; i < 24; i++) begin
      logic [7:0] idx, dat;
      idx = 8'((i * 11 + 3) % 256);
      dat = 8'((i * 37 + 5) % 256);
      busStart();
      sendByte({MY_ADDR, 1'b0}, 1'b1, -1, a0);
      sendByte(idx, 1'b1, -1, a1);
      sendByte(dat, 1'b1, -1, a2);
      busStop();
      expMem[idx] = dat;
      chk(a0 && a1 && a2, "R3 write acks", int'({a0, a1, a2}), 7);
      chk(regMem[idx] == dat, "R3 write data", int'(regMem[idx]), int'(dat));
      wrBase = wrCount;
      setIdx(idx, 1'b1);
      chk(regIdx == idx, "R4 pointer loaded", int'(regIdx), int'(idx));
      chk(wrCount == wrBase, "R4 no write", wrCount, wrBase);
      doRead(rd);
      chk(rd == expMem[idx], "R5 read data", int'(rd), int'(expMem[idx]));
    end

    // R5 pointer persists over reads of an unwritten register
    setIdx(8'hC7, 1'b1);
    doRead(rd);
    doRead(rd2);
    chk(rd == expMem[8'hC7], "R5 first read", int'(rd), int'(expMem[8'hC7]));
    chk(rd2 == rd, "R5 repeated read", int'(rd2), int'(rd));
    chk(regIdx == 8'hC7, "R5 pointer kept", int'(regIdx), 'hC7);

    // R6 foreign address followed by index and data
    wrBase = wrCount;
    busStart();
    sendByte({7'h2E, 1'b0}, 1'b0, -1, a0);
    sendByte(8'h10, 1'b0, -1, a1);
    sendByte(8'h99, 1'b0, -1, a2);
    busStop();
    chk(!a0 && !a1 && !a2, "R6 no acks", int'({a0, a1, a2}), 0);
    chk(wrCount == wrBase, "R6 no write", wrCount, wrBase);
    chk(regIdx == 8'hC7, "R6 pointer kept", int'(regIdx), 'hC7);

    // R7 stop inside the data byte
    wrBase = wrCount;
    busStart();
    sendByte({MY_ADDR, 1'b0}, 1'b1, -1, a0);
    sendByte(8'h20, 1'b1, -1, a1);
    for (int i = 0; i < 4; i++) putBit(1'b0, 1'b0);
    busStop();
    chk(wrCount == wrBase, "R7 stop abort", wrCount, wrBase);
    chk(regMem[8'h20] == expMem[8'h20], "R7 data kept",
        int'(regMem[8'h20]), int'(expMem[8'h20]));

    // R7 repeated start inside the data byte, then a read
    busStart();
    sendByte({MY_ADDR, 1'b0}, 1'b1, -1, a0);
    sendByte(8'h21, 1'b1, -1, a1);
    for (int i = 0; i < 5; i++) putBit(1'b1, 1'b0);
    busStart();
    sendByte({MY_ADDR, 1'b1}, 1'b0, -1, a0);
    recvByte(1'b0, rd);
    busStop();
    chk(wrCount == wrBase, "R7 start abort", wrCount, wrBase);
    chk(rd == expMem[8'h21], "R7 read after abort", int'(rd), int'(expMem[8'h21]));

    // R8 trailing byte after data is refused
    busStart();
    sendByte({MY_ADDR, 1'b0}, 1'b1, -1, a0);
    sendByte(8'h30, 1'b1, -1, a1);
    sendByte(8'h5A, 1'b1, -1, a2);
    sendByte(8'hC3, 1'b0, -1, a3);
    busStop();
    expMem[8'h30] = 8'h5A;
    chk(a2 && !a3, "R8 trailing nack", int'({a2, a3}), 2);
    chk(regMem[8'h30] == 8'h5A, "R8 first data kept", int'(regMem[8'h30]), 'h5A);
    chk(wrCount == wrBase + 1, "R8 single write", wrCount, wrBase + 1);

    // R11 index-only closed by repeated start, then read
    setIdx(8'h30, 1'b0);
    busStart();
    sendByte({MY_ADDR, 1'b1}, 1'b0, -1, a0);
    recvByte(1'b0, rd);
    busStop();
    chk(a0, "R11 read ack", int'(a0), 1);
    chk(rd == 8'h5A, "R11 read new index", int'(rd), 'h5A);

    // R10 short SDA pulse while SCL high inside a data byte
    busStart();
    sendByte({MY_ADDR, 1'b0}, 1'b1, -1, a0);
    sendByte(8'h44, 1'b1, -1, a1);
    sendByte(8'hB6, 1'b1, 5, a2);
    busStop();
    expMem[8'h44] = 8'hB6;
    chk(a2, "R10 data ack after glitch", int'(a2), 1);
    chk(regMem[8'h44] == 8'hB6, "R10 data after glitch", int'(regMem[8'h44]), 'hB6);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule